// File: doc/BRIEF.md
# PPP HDLC Transmit Framer

This block turns a stream of packets, presented one byte per beat with valid, start, end and error markers, into an octet-synchronous HDLC-like line stream. The line side pulls octets: every cycle it raises its request, the framer hands back exactly one octet a cycle later. Packets are wrapped between flag octets, protected by a frame check sequence that the framer computes and appends, and made transparent by escaping the two octets that carry framing meaning.

When nothing is queued the line is filled with flags. Consecutive frames share a single flag. A frame can be cut short in two ways: the source marks its last beat as bad, or the source runs dry in the middle of a packet. Either way the framer closes the frame with an abort sequence. After a mid-packet underrun it silently swallows the rest of that packet and resumes normally with the next one. Each finished frame raises a one-cycle event, and two saturating counters with clear-on-read tally good and errored frames.

Top module: `ppp_hdlc_tx_framer`

## Requirements
- R1: After reset, and whenever no packet is being sent, each requested octet is the flag 0x7E.
- R2: An octet is produced only for a request: `line_vld` is high exactly in the cycle after a cycle with `line_req` high, and the octet stream does not depend on gaps in the requests.
- R3: A payload or check octet equal to 0x7E or 0x7D is sent as 0x7D followed by the octet XOR 0x20. No other value is escaped. The second slot of an escape takes no source beat, so a packet of N beats containing E such octets, pulled with requests held high, spans N+E-1 cycles from its first to its last transfer.
- R4: After the last good beat the framer appends the complemented CRC, least significant octet first. With `crc32_sel` high at the first beat this is the 32-bit CRC (reflected polynomial 0xEDB88320) in 4 octets. Otherwise it is the 16-bit CCITT CRC (reflected polynomial 0x8408) in 2 octets. Both registers start at all ones.
- R5: A frame leaving idle is preceded by flags only. A single 0x7E after the check octets closes a frame and also opens the next one when packets follow back to back.
- R6: A last beat with `src_err` high is sent, then followed by 0x7D 0x7E instead of the check octets. This pulses `evt_abort` and counts as an error.
- R7: If `src_valid` is low on a request in the middle of a packet, the framer sends 0x7D 0x7E and pulses `evt_underrun`. The event counts as an error. The rest of the packet, through its end beat, is accepted and dropped with no output, and the next packet is framed normally.
- R8: `src_valid` low between packets only yields flags and raises no event.
- R9: `evt_good` pulses once for each frame that completes its check octets, together with the last check octet, and the good counter counts it.
- R10: Both counters stop at all ones (0xFFFF with the default 16-bit width) and never wrap.
- R11: A cycle with `rd_good` or `rd_err` high clears the matching counter. An event in that same cycle leaves a value of 1.
- R12: A valid beat without `src_sop` arriving between packets is consumed and dropped, and only flags are sent for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc32_sel | input | 1 | 1: 32-bit check, 0: 16-bit check; sampled at a frame's first beat |
| src_valid | input | 1 | Source beat valid |
| src_sop | input | 1 | Beat is the first of a packet |
| src_eop | input | 1 | Beat is the last of a packet |
| src_err | input | 1 | With `src_eop`, abort the frame |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Beat is taken in this cycle when valid |
| line_req | input | 1 | Line asks for one octet |
| line_data | output | 8 | Line octet |
| line_vld | output | 1 | `line_data` holds the octet for the previous request |
| evt_good | output | 1 | Frame finished with its check octets |
| evt_abort | output | 1 | Frame aborted on source error |
| evt_underrun | output | 1 | Frame aborted on source underrun |
| rd_good | input | 1 | Read strobe, clears the good counter |
| rd_err | input | 1 | Read strobe, clears the error counter |
| good_cnt | output | CNT_W | Saturating good-frame count |
| err_cnt | output | CNT_W | Saturating aborted-frame count |

## Verification
A stale escape flag or a wrong state shows in the next requested octet: an unpaired 0x7D, a doubled or missing flag, or a payload octet repeated or skipped. A corrupted check register shows only at the end of the frame, in the 2 or 4 check octets. That is why every frame's full octet sequence, flags included, is compared against a stream built arithmetically in the bench. A lost drop state surfaces only when the beats after an underrun leak onto the line, so the bench follows each underrun with its remaining beats and then a fresh frame.

// File: rtl/ppp_tx_pkg.sv
package ppp_tx_pkg;
  localparam int          OCT_W     = 8;
  localparam int          FCS_W     = 32;
  localparam logic [7:0]  FLAG_OCT  = 8'h7E;
  localparam logic [7:0]  ESC_OCT   = 8'h7D;
  localparam logic [7:0]  FLIP_MASK = 8'h20;
  localparam logic [31:0] POLY32_R  = 32'hEDB88320;
  localparam logic [15:0] POLY16_R  = 16'h8408;

  typedef enum logic [2:0] {
    ST_CLOSE,  // emit one flag, then wait in gap
    ST_GAP,    // last octet was a flag
    ST_BODY,   // inside payload
    ST_FCS,    // emitting check octets
    ST_ABORT   // emit escape half of abort
  } tx_state_e;

  function automatic logic needs_esc(input logic [OCT_W-1:0] b);
    return (b == FLAG_OCT) || (b == ESC_OCT);
  endfunction

  // one byte of reflected CRC, bit 0 of the byte first
  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c,
                                                input logic [OCT_W-1:0] d,
                                                input logic wide);
    logic [FCS_W-1:0] r;
    logic             fb;
    r = c;
    if (!wide) r[31:16] = '0;
    for (int i = 0; i < OCT_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ (wide ? POLY32_R : {16'h0000, POLY16_R});
    end
    return r;
  endfunction
endpackage

// File: rtl/ppp_tx_fcs.sv
module ppp_tx_fcs
  import ppp_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             restart,
  input  logic             wide,
  input  logic [OCT_W-1:0] octet,
  output logic [FCS_W-1:0] fcs_out
);
  logic [FCS_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= '1;
    else if (load) crc_q <= fcs_step(restart ? '1 : crc_q, octet, wide);
  end

  assign fcs_out = ~crc_q;
endmodule

// File: rtl/ppp_tx_satcnt.sv
module ppp_tx_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (clr)               cnt <= inc ? ONE : '0;
    else if (inc && cnt != TOP) cnt <= cnt + ONE;
  end

  // R10: once at the top the count stays there until read
  a_r10_hold_at_top: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP && !clr) |=> (cnt == TOP));

  // R11: a read leaves at most the one event of that cycle
  a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt <= ONE));
endmodule

// File: rtl/ppp_hdlc_tx_framer.sv
module ppp_hdlc_tx_framer
  import ppp_tx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crc32_sel,
  input  logic             src_valid,
  input  logic             src_sop,
  input  logic             src_eop,
  input  logic             src_err,
  input  logic [OCT_W-1:0] src_data,
  output logic             src_ready,
  input  logic             line_req,
  output logic [OCT_W-1:0] line_data,
  output logic             line_vld,
  output logic             evt_good,
  output logic             evt_abort,
  output logic             evt_underrun,
  input  logic             rd_good,
  input  logic             rd_err,
  output logic [CNT_W-1:0] good_cnt,
  output logic [CNT_W-1:0] err_cnt
);
  localparam int N_CNT = 2;
  localparam int IDX_W = $clog2(FCS_W / OCT_W);

  tx_state_e        st_q, st_d;
  logic             esc_q, esc_d, drop_q, drop_d, wide_q, wide_d;
  logic [OCT_W-1:0] hold_q, hold_d, out_d, pick;
  logic [IDX_W-1:0] idx_q, idx_d, last_idx;
  logic             take, first, put, good_d, abt_d, und_d;
  logic [FCS_W-1:0] fcs_val;

  assign last_idx  = wide_q ? IDX_W'(FCS_W / OCT_W - 1) : IDX_W'(1);
  assign src_ready = drop_q | (line_req & ~esc_q & (st_q == ST_GAP | st_q == ST_BODY));

  ppp_tx_fcs u_fcs (
    .clk     (clk),
    .rst     (rst),
    .load    (take),
    .restart (first),
    .wide    (first ? crc32_sel : wide_q),
    .octet   (src_data),
    .fcs_out (fcs_val)
  );

  always_comb begin
    st_d   = st_q;   esc_d  = esc_q;  hold_d = hold_q; idx_d = idx_q;
    drop_d = drop_q; wide_d = wide_q;
    out_d  = FLAG_OCT; pick = src_data;
    take   = 1'b0; first = 1'b0; put = 1'b0;
    good_d = 1'b0; abt_d = 1'b0; und_d = 1'b0;
    if (drop_q && src_valid && src_eop) drop_d = 1'b0;
    if (line_req) begin
      if (esc_q) begin
        out_d = hold_q;
        esc_d = 1'b0;
      end else begin
        case (st_q)
          ST_CLOSE: st_d = ST_GAP;
          ST_GAP: if (!drop_q && src_valid && src_sop) begin
            take = 1'b1; first = 1'b1; put = 1'b1; wide_d = crc32_sel;
            st_d = src_eop ? (src_err ? ST_ABORT : ST_FCS) : ST_BODY;
          end
          ST_BODY: if (src_valid) begin
            take = 1'b1; put = 1'b1;
            st_d = src_eop ? (src_err ? ST_ABORT : ST_FCS) : ST_BODY;
          end else begin
            out_d = ESC_OCT; st_d = ST_CLOSE; und_d = 1'b1; drop_d = 1'b1;
          end
          ST_FCS: begin
            put   = 1'b1;
            pick  = fcs_val[{idx_q, 3'b000} +: OCT_W];
            idx_d = idx_q + IDX_W'(1);
            if (idx_q == last_idx) begin
              idx_d = '0; st_d = ST_CLOSE; good_d = 1'b1;
            end
          end
          ST_ABORT: begin
            out_d = ESC_OCT; st_d = ST_CLOSE; abt_d = 1'b1;
          end
          default: st_d = ST_CLOSE;
        endcase
        if (put) begin
          if (needs_esc(pick)) begin
            out_d = ESC_OCT; esc_d = 1'b1; hold_d = pick ^ FLIP_MASK;
          end else begin
            out_d = pick;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_CLOSE; esc_q <= 1'b0; drop_q <= 1'b0; wide_q <= 1'b0;
      hold_q <= '0; idx_q <= '0;
      line_data <= FLAG_OCT; line_vld <= 1'b0;
      evt_good <= 1'b0; evt_abort <= 1'b0; evt_underrun <= 1'b0;
    end else begin
      st_q <= st_d; esc_q <= esc_d; drop_q <= drop_d; wide_q <= wide_d;
      hold_q <= hold_d; idx_q <= idx_d;
      line_vld <= line_req;
      if (line_req) line_data <= out_d;
      evt_good <= good_d; evt_abort <= abt_d; evt_underrun <= und_d;
    end
  end

  logic [N_CNT-1:0]            cnt_inc, cnt_clr;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_val;
  assign cnt_inc = {evt_abort | evt_underrun, evt_good};
  assign cnt_clr = {rd_err, rd_good};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    ppp_tx_satcnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (cnt_inc[g]),
      .clr (cnt_clr[g]),
      .cnt (cnt_val[g])
    );
  end
  assign good_cnt = cnt_val[0];
  assign err_cnt  = cnt_val[1];

  // last octet on the line was an escape
  logic esc_seen_q;
  always_ff @(posedge clk) begin
    if (rst)           esc_seen_q <= 1'b0;
    else if (line_vld) esc_seen_q <= (line_data == ESC_OCT);
  end

  // R3: an escape is always followed by an escaped value or a closing flag
  a_r3_escape_pair: assert property (@(posedge clk) disable iff (rst)
    (line_vld && esc_seen_q) |->
      (line_data == (FLAG_OCT ^ FLIP_MASK) || line_data == (ESC_OCT ^ FLIP_MASK) ||
       line_data == FLAG_OCT));

  // R9: at most one frame outcome per cycle
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_good, evt_abort, evt_underrun}));

  // R6: a host abort goes out with the escape half of the abort sequence
  a_r6_abort_octet: assert property (@(posedge clk) disable iff (rst)
    evt_abort |-> (line_vld && line_data == ESC_OCT));

  // R7: an underrun goes out with the escape half of the abort sequence
  a_r7_underrun_octet: assert property (@(posedge clk) disable iff (rst)
    evt_underrun |-> (line_vld && line_data == ESC_OCT));
endmodule

// File: tb/test_ppp_hdlc_tx_framer.sv
module test_ppp_hdlc_tx_framer;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          crc32_sel = 1'b0;
  logic          src_valid = 1'b0, src_sop = 1'b0, src_eop = 1'b0, src_err = 1'b0;
  logic [7:0]    src_data = '0;
  logic          src_ready;
  logic          line_req = 1'b0;
  logic [7:0]    line_data;
  logic          line_vld;
  logic          evt_good, evt_abort, evt_underrun;
  logic          rd_good = 1'b0, rd_err = 1'b0;
  logic [CW-1:0] good_cnt, err_cnt;

  ppp_hdlc_tx_framer #(.CNT_W(CW)) i_ppp_hdlc_tx_framer (
    .clk(clk), .rst(rst), .crc32_sel(crc32_sel),
    .src_valid(src_valid), .src_sop(src_sop), .src_eop(src_eop), .src_err(src_err),
    .src_data(src_data), .src_ready(src_ready),
    .line_req(line_req), .line_data(line_data), .line_vld(line_vld),
    .evt_good(evt_good), .evt_abort(evt_abort), .evt_underrun(evt_underrun),
    .rd_good(rd_good), .rd_err(rd_err), .good_cnt(good_cnt), .err_cnt(err_cnt)
  );

  int total = 0, bad = 0;
  logic [7:0] cap [0:4095];
  int ncap = 0;
  logic [7:0] exp_oct [0:2047];
  int ne = 0;
  logic [7:0] pay [0:511];
  int n_good = 0, n_abt = 0, n_und = 0, ncyc = 0;
  int req_mode = 0;  // 0 low, 1 high, 2 alternate
  int t_first = 0, t_last = 0;

  always @(posedge clk) ncyc <= ncyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (line_vld && ncap < 4096) begin cap[ncap] = line_data; ncap++; end
      n_good += int'(evt_good);
      n_abt  += int'(evt_abort);
      n_und  += int'(evt_underrun);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      case (req_mode)
        1:       line_req = 1'b1;
        2:       line_req = ~line_req;
        default: line_req = 1'b0;
      endcase
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int off, input int n, input logic wide);
    logic [31:0] c;
    logic        fb;
    c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ pay[off+i][b];
        c  = c >> 1;
        if (fb) c = c ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
      end
    return wide ? ~c : {16'h0000, ~c[15:0]};
  endfunction

  task automatic add_oct(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin
      exp_oct[ne] = 8'h7D; exp_oct[ne+1] = b ^ 8'h20; ne += 2;
    end else begin
      exp_oct[ne] = b; ne++;
    end
  endtask

  // kind 0 good, 1 host abort, 2 underrun after keep beats
  task automatic add_frame(input int off, input int n, input logic wide,
                           input int kind, input int keep);
    logic [31:0] f;
    int m;
    m = (kind == 2) ? keep : n;
    for (int i = 0; i < m; i++) add_oct(pay[off+i]);
    if (kind == 0) begin
      f = ref_fcs(off, n, wide);
      for (int k = 0; k < (wide ? 4 : 2); k++) add_oct(f[8*k +: 8]);
    end else begin
      exp_oct[ne] = 8'h7D; ne++;
    end
    exp_oct[ne] = 8'h7E; ne++;
  endtask

  task automatic send(input int off, input int n, input logic err, input int cut);
    for (int i = 0; i < n; i++) begin
      if (i == cut) begin
        @(negedge clk);
        src_valid = 1'b0;
        @(posedge clk);
      end
      @(negedge clk);
      src_valid = 1'b1; src_data = pay[off+i];
      src_sop = (i == 0); src_eop = (i == n - 1); src_err = err && (i == n - 1);
      #1;
      while (!src_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      #1;
      if (i == 0) t_first = ncyc;
      t_last = ncyc;
    end
    @(negedge clk);
    src_valid = 1'b0; src_sop = 1'b0; src_eop = 1'b0; src_err = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_stream(input string req);
    int s = 0;
    int at = -1;
    while (s < ncap && cap[s] == 8'h7E) s++;
    for (int i = 0; i < ne; i++)
      if (at < 0 && (s + i >= ncap || cap[s+i] != exp_oct[i])) at = i;
    for (int i = s + ne; i < ncap; i++)
      if (at < 0 && cap[i] != 8'h7E) at = i - s;
    total++;
    if (at >= 0) begin
      bad++;
      $display("FAIL %s stream octet %0d act=%02h exp=%02h", req, at,
               (s + at < ncap) ? cap[s+at] : 8'h00, (at < ne) ? exp_oct[at] : 8'h7E);
    end
  endtask

  task automatic start_case();
    ncap = 0; ne = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int exp_good, n0, all_flags;
    exp_good = 0;
    idle(4);
    rst = 1'b0;
    idle(2);
    // R2, R10, R11: reset state with no requests
    check("R2", "line_vld after reset", 32'(line_vld), 0);
    check("R11", "good_cnt after reset", 32'(good_cnt), 0);
    check("R11", "err_cnt after reset", 32'(err_cnt), 0);
    check("R2", "src_ready without request", 32'(src_ready), 0);

    // R1: idle line is all flags
    start_case();
    req_mode = 1; idle(8); req_mode = 0; idle(3);
    all_flags = 1;
    for (int i = 0; i < ncap; i++) if (cap[i] != 8'h7E) all_flags = 0;
    check("R1", "idle octets are flags", 32'(all_flags), 1);
    check("R1", "idle octets seen", 32'(ncap >= 7), 1);
    n0 = ncap; idle(6);
    check("R2", "no octet without request", 32'(ncap), 32'(n0));
    req_mode = 1; idle(2);

    // R4: check values of the standard nine-digit vector
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    check("R4", "bench crc32 vector", ref_fcs(0, 9, 1'b1), 32'hCBF4_3926);
    check("R4", "bench crc16 vector", ref_fcs(0, 9, 1'b0), 32'h0000_906E);
    for (int w = 0; w < 2; w++) begin
      start_case(); crc32_sel = w[0];
      add_frame(0, 9, w[0], 0, 0);
      send(0, 9, 1'b0, -1); idle(16);
      check_stream(w == 1 ? "R4 crc32 digits" : "R4 crc16 digits");
      exp_good++;
    end

    // R3 R4 R5: sweep of lengths and modes with escaped octets mixed in
    for (int w = 0; w < 2; w++)
      for (int len = 1; len <= 8; len++) begin
        for (int i = 0; i < len; i++)
          pay[i] = ((i + len) % 3 == 0) ? 8'h7E :
                   ((i + len) % 3 == 1) ? 8'h7D : 8'(i * 37 + len);
        start_case(); crc32_sel = w[0];
        add_frame(0, len, w[0], 0, 0);
        send(0, len, 1'b0, -1); idle(24);
        check_stream("R3 R4 R5 sweep");
        exp_good++;
      end

    // R3: every byte value, escape stalls counted in transfer cycles
    for (int i = 0; i < 256; i++) pay[i] = 8'(i);
    start_case(); crc32_sel = 1'b1;
    add_frame(0, 256, 1'b1, 0, 0);
    send(0, 256, 1'b0, -1); idle(20);
    check_stream("R3 all values");
    check("R3", "transfer span cycles", 32'(t_last - t_first), 257);
    exp_good++;

    // R2: alternating requests give the same octet stream
    for (int i = 0; i < 10; i++) pay[i] = 8'(8'h70 + i * 3);
    start_case(); crc32_sel = 1'b0; req_mode = 2;
    add_frame(0, 10, 1'b0, 0, 0);
    send(0, 10, 1'b0, -1); idle(40);
    req_mode = 1; idle(4);
    check_stream("R2 sparse requests");
    exp_good++;

    // R5: back to back frames share one flag
    for (int i = 0; i < 12; i++) pay[i] = 8'(8'hA0 + i);
    pay[3] = 8'h7E; pay[9] = 8'h7D;
    start_case(); crc32_sel = 1'b1;
    add_frame(0, 5, 1'b1, 0, 0);
    add_frame(5, 7, 1'b1, 0, 0);
    send(0, 5, 1'b0, -1); send(5, 7, 1'b0, -1); idle(24);
    check_stream("R5 shared flag");
    exp_good += 2;
    check("R9", "good events so far", 32'(n_good), 32'(exp_good));

    // R6: host abort on the last beat
    for (int i = 0; i < 3; i++) pay[i] = 8'(8'h11 * (i + 1));
    start_case(); crc32_sel = 1'b0;
    add_frame(0, 3, 1'b0, 1, 0);
    send(0, 3, 1'b1, -1); idle(16);
    check_stream("R6 abort");
    check("R6", "abort events", 32'(n_abt), 1);
    check("R6", "err_cnt after abort", 32'(err_cnt), 1);

    // R7: underrun after two beats, rest of packet dropped
    for (int i = 0; i < 6; i++) pay[i] = 8'(8'h21 + i);
    start_case();
    add_frame(0, 6, 1'b0, 2, 2);
    send(0, 6, 1'b0, 2); idle(16);
    check_stream("R7 underrun");
    check("R7", "underrun events", 32'(n_und), 1);
    check("R7", "err_cnt after underrun", 32'(err_cnt), 2);
    for (int i = 0; i < 4; i++) pay[i] = 8'(8'h51 + i);
    start_case();
    add_frame(0, 4, 1'b0, 0, 0);
    send(0, 4, 1'b0, -1); idle(16);
    check_stream("R7 next frame");
    exp_good++;

    // R12: stray beat between packets, then a normal frame
    start_case();
    @(negedge clk);
    src_valid = 1'b1; src_sop = 1'b0; src_eop = 1'b1; src_data = 8'h33;
    #1; while (!src_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); src_valid = 1'b0; src_eop = 1'b0;
    idle(4);
    for (int i = 0; i < 2; i++) pay[i] = 8'(8'h61 + i);
    add_frame(0, 2, 1'b0, 0, 0);
    send(0, 2, 1'b0, -1); idle(16);
    check_stream("R12 stray beat");
    exp_good++;

    // R8: gaps between packets raised no further outcomes
    check("R8", "underrun events unchanged", 32'(n_und), 1);
    check("R8", "abort events unchanged", 32'(n_abt), 1);
    check("R9", "good events", 32'(n_good), 32'(exp_good));
    check("R10", "good_cnt saturated", 32'(good_cnt), 32'(exp_good > 15 ? 15 : exp_good));

    // R11: clear on read
    @(negedge clk); rd_good = 1'b1; rd_err = 1'b1;
    @(negedge clk); rd_good = 1'b0; rd_err = 1'b0;
    check("R11", "good_cnt cleared", 32'(good_cnt), 0);
    check("R11", "err_cnt cleared", 32'(err_cnt), 0);

    // R10: run the small counter past its top
    pay[0] = 8'h41;
    crc32_sel = 1'b0;
    for (int k = 0; k < 17; k++) begin
      send(0, 1, 1'b0, -1);
      if (k == 13) begin idle(12); check("R10", "good_cnt below top", 32'(good_cnt), 14); end
    end
    idle(12);
    check("R10", "good_cnt holds at top", 32'(good_cnt), 15);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule